// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a small RISC core. Registers 0 through 7 are kept in two physical copies, a low bank and a high bank. Registers 8 through 15 exist once and are shared by both banks. That makes 24 storage words in total. A privilege flag and a bank-select flag, both taken from outside and used every cycle, decide which copy of registers 0 to 7 the operand ports see.

Two combinational read ports and one clocked write port serve normal instruction operands. A separate transfer port takes a 3-bit index and reaches only the copy of registers 0 to 7 that is currently hidden. Register-transfer operations use it to save or restore the other context. A dedicated output always shows register 0 of the visible bank, for use by indexed addressing.

Top module: `banked_gpr_file`

## Requirements
- R1: The active-low asynchronous reset clears all 24 storage words to zero as soon as it is asserted. Afterwards every read port, the transfer port and the base output read zero in every mode.
- R2: With the privilege flag at 0 (user), indices 0-7 on the operand ports select the low bank, whatever the bank-select flag is.
- R3: With the privilege flag at 1 and the bank-select flag at 1, indices 0-7 on the operand ports select the high bank.
- R4: With the privilege flag at 1 and the bank-select flag at 0, indices 0-7 on the operand ports select the low bank.
- R5: Indices 8-15 select one shared word in every mode, so a value written in one mode can be read back in any other mode.
- R6: The transfer port reads and writes the bank that is not visible (the high bank unless privileged with bank-select 1, in which case the low bank). An operand-port write never changes a word seen through the transfer port.
- R7: The base output equals register 0 of the visible bank.
- R8: Reads are combinational. A write lands on the rising clock edge, and a read of the same word in the write cycle returns the old value.
- R9: The two read ports take independent indices and return their own words in the same cycle.
- R10: An operand write and a transfer write in the same cycle both land, because they always target different words. If they ever targeted the same word, the operand write would take priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| bank_sel_i | input | 1 | Bank-select flag; takes effect only in privileged mode |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Operand write enable |
| wr_idx_i | input | 4 | Operand write register index |
| wr_data_i | input | 32 | Operand write data |
| alt_idx_i | input | 3 | Hidden-bank transfer index (registers 0-7) |
| alt_we_i | input | 1 | Hidden-bank transfer write enable |
| alt_wdata_i | input | 32 | Hidden-bank transfer write data |
| alt_rdata_o | output | 32 | Hidden-bank transfer read data |
| idx_base_o | output | 32 | Register 0 of the visible bank |

## Verification
The hardest case to reach is the same-cycle operand write and transfer write with equal indices. The two writes must land in opposite banks, and that can only be seen afterwards by swapping the mode so each copy becomes visible in turn. The bench sets this up directly. It then reads each copy through the operand port in one mode and through the transfer port in the other. It also shows that writes through one path never leak into the word seen by the other path, by re-reading the hidden word after an operand write to the same index.

// File: rtl/banked_gpr_pkg.sv
package banked_gpr_pkg;
  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_e;
endpackage

// File: rtl/gpr_bank_ctrl.sv
module gpr_bank_ctrl
  import banked_gpr_pkg::*;
(
  input  logic  priv_i,
  input  logic  bank_sel_i,
  output bank_e act_bank_o,
  output bank_e alt_bank_o
);
  // bank-select is only honoured in privileged mode
  always_comb begin
    act_bank_o = (priv_i && bank_sel_i) ? BANK_HI : BANK_LO;
    alt_bank_o = (act_bank_o == BANK_HI) ? BANK_LO : BANK_HI;
  end
endmodule

// File: rtl/gpr_addr_map.sv
module gpr_addr_map
  import banked_gpr_pkg::*;
#(
  parameter int NUM_BANKED = 8,
  parameter int NUM_SHARED = 8,
  localparam int ARCH_W = $clog2(NUM_BANKED + NUM_SHARED),
  localparam int PHYS_W = $clog2(2 * NUM_BANKED + NUM_SHARED)
) (
  input  logic [ARCH_W-1:0] arch_idx_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o
);
  // layout: [0,NB) low bank, [NB,2NB) high bank, [2NB,2NB+NS) shared
  logic [PHYS_W-1:0] idx_ext;
  logic              is_shared;

  always_comb begin
    idx_ext   = PHYS_W'(arch_idx_i);
    is_shared = idx_ext >= PHYS_W'(NUM_BANKED);
    phys_o    = (is_shared || bank_i == BANK_HI) ? idx_ext + PHYS_W'(NUM_BANKED) : idx_ext;
  end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int DATA_W = 32,
  parameter int NWORDS = 24,
  localparam int PHYS_W = $clog2(NWORDS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [PHYS_W-1:0]              waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           alt_we_i,
  input  logic [PHYS_W-1:0]              alt_addr_i,
  input  logic [DATA_W-1:0]              alt_wdata_i,
  output logic [NWORDS-1:0][DATA_W-1:0]  words_o
);
  logic [DATA_W-1:0] mem_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic hit_n, hit_a;
    assign hit_n = we_i && (waddr_i == PHYS_W'(g));
    assign hit_a = alt_we_i && (alt_addr_i == PHYS_W'(g));
    // operand write has priority on a shared target
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    mem_q[g] <= '0;
      else if (hit_n) mem_q[g] <= wdata_i;
      else if (hit_a) mem_q[g] <= alt_wdata_i;
    end
  end

  always_comb begin
    for (int i = 0; i < NWORDS; i++) words_o[i] = mem_q[i];
  end

  // R8
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

  // R10
  no_collision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && alt_we_i && waddr_i == alt_addr_i));

  // R10
  alt_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_we_i && !(we_i && waddr_i == alt_addr_i)) |=> mem_q[$past(alt_addr_i)] == $past(alt_wdata_i));
endmodule

// File: rtl/banked_gpr_file.sv
module banked_gpr_file
  import banked_gpr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_BANKED = 8,
  parameter int NUM_SHARED = 8,
  localparam int ARCH_W = $clog2(NUM_BANKED + NUM_SHARED),
  localparam int ALT_W  = $clog2(NUM_BANKED)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic              bank_sel_i,
  input  logic [ARCH_W-1:0] rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ARCH_W-1:0] rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [ARCH_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ALT_W-1:0]  alt_idx_i,
  input  logic              alt_we_i,
  input  logic [DATA_W-1:0] alt_wdata_i,
  output logic [DATA_W-1:0] alt_rdata_o,
  output logic [DATA_W-1:0] idx_base_o
);
  localparam int NWORDS = 2 * NUM_BANKED + NUM_SHARED;
  localparam int PHYS_W = $clog2(NWORDS);
  // map slots: 0 rd_a, 1 rd_b, 2 wr, 3 alt, 4 base
  localparam int N_MAP  = 5;

  bank_e act_bank, alt_bank;
  logic [N_MAP-1:0][ARCH_W-1:0] map_idx;
  logic [N_MAP-1:0][PHYS_W-1:0] map_phys;
  bank_e                        map_bank [N_MAP];
  logic [NWORDS-1:0][DATA_W-1:0] words;

  gpr_bank_ctrl u_ctrl (
    .priv_i     (priv_i),
    .bank_sel_i (bank_sel_i),
    .act_bank_o (act_bank),
    .alt_bank_o (alt_bank)
  );

  always_comb begin
    map_idx[0]  = rd_a_idx_i;
    map_idx[1]  = rd_b_idx_i;
    map_idx[2]  = wr_idx_i;
    map_idx[3]  = ARCH_W'(alt_idx_i);
    map_idx[4]  = '0;
    map_bank[0] = act_bank;
    map_bank[1] = act_bank;
    map_bank[2] = act_bank;
    map_bank[3] = alt_bank;
    map_bank[4] = act_bank;
  end

  for (genvar p = 0; p < N_MAP; p++) begin : g_map
    gpr_addr_map #(
      .NUM_BANKED (NUM_BANKED),
      .NUM_SHARED (NUM_SHARED)
    ) u_map (
      .arch_idx_i (map_idx[p]),
      .bank_i     (map_bank[p]),
      .phys_o     (map_phys[p])
    );
  end

  gpr_storage #(
    .DATA_W (DATA_W),
    .NWORDS (NWORDS)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (wr_en_i),
    .waddr_i     (map_phys[2]),
    .wdata_i     (wr_data_i),
    .alt_we_i    (alt_we_i),
    .alt_addr_i  (map_phys[3]),
    .alt_wdata_i (alt_wdata_i),
    .words_o     (words)
  );

  always_comb begin
    rd_a_data_o = words[map_phys[0]];
    rd_b_data_o = words[map_phys[1]];
    alt_rdata_o = words[map_phys[3]];
    idx_base_o  = words[map_phys[4]];
  end

  // R6
  alt_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!alt_we_i) && $stable(alt_idx_i) && $stable(act_bank)) |-> $stable(alt_rdata_o));

  // R7
  base_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!(wr_en_i && wr_idx_i == '0)) && $stable(act_bank)) |-> $stable(idx_base_o));
endmodule

// File: tb/banked_gpr_file_tb.sv
module banked_gpr_file_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        priv_i, bank_sel_i;
  logic [3:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i;
  logic        wr_en_i, alt_we_i;
  logic [2:0]  alt_idx_i;
  logic [31:0] alt_wdata_i, alt_rdata_o, idx_base_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  banked_gpr_file u_dut (
    .clk_i, .rst_ni, .priv_i, .bank_sel_i,
    .rd_a_idx_i, .rd_a_data_o, .rd_b_idx_i, .rd_b_data_o,
    .wr_en_i, .wr_idx_i, .wr_data_i,
    .alt_idx_i, .alt_we_i, .alt_wdata_i, .alt_rdata_o, .idx_base_o
  );

  typedef struct packed {
    logic        priv;
    logic        bank;
    logic        we;
    logic [3:0]  widx;
    logic [31:0] wdata;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] ea;
    logic [31:0] eb;
  } vec_t;

  // reads are checked before the row's own write lands
  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b0, 1'b1, 4'd1,  32'h11111111, 4'd1,  4'd9,  32'h0,        32'h0},
    '{1'b0, 1'b1, 1'b1, 4'd9,  32'h99999999, 4'd1,  4'd9,  32'h11111111, 32'h0},
    '{1'b1, 1'b1, 1'b1, 4'd1,  32'hA1A1A1A1, 4'd1,  4'd9,  32'h0,        32'h99999999},
    '{1'b1, 1'b0, 1'b1, 4'd2,  32'h22222222, 4'd1,  4'd1,  32'h11111111, 32'h11111111},
    '{1'b1, 1'b1, 1'b0, 4'd0,  32'h0,        4'd1,  4'd2,  32'hA1A1A1A1, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'd0,  32'h0,        4'd2,  4'd9,  32'h22222222, 32'h99999999},
    '{1'b1, 1'b1, 1'b1, 4'd15, 32'hFFFF0000, 4'd15, 4'd1,  32'h0,        32'hA1A1A1A1},
    '{1'b0, 1'b0, 1'b0, 4'd0,  32'h0,        4'd15, 4'd15, 32'hFFFF0000, 32'hFFFF0000}
  };

  function automatic string vec_req(int i);
    case (i)
      0: return "R8";
      1: return "R2";
      2: return "R3 R5";
      3: return "R4";
      4: return "R3";
      5: return "R2 R5";
      6: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_mode(logic p, logic b);
    priv_i = p;
    bank_sel_i = b;
  endtask

  task automatic check_all_zero(string req);
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0], m[0]);
      for (int i = 0; i < 16; i++) begin
        rd_a_idx_i = 4'(i);
        rd_b_idx_i = 4'(15 - i);
        #1;
        chk(req, rd_a_data_o, 32'h0);
        chk(req, rd_b_data_o, 32'h0);
      end
      for (int j = 0; j < 8; j++) begin
        alt_idx_i = 3'(j);
        #1;
        chk(req, alt_rdata_o, 32'h0);
      end
      chk(req, idx_base_o, 32'h0);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    set_mode(1'b0, 1'b0);
    rd_a_idx_i = '0; rd_b_idx_i = '0;
    wr_en_i = 1'b0; wr_idx_i = '0; wr_data_i = '0;
    alt_we_i = 1'b0; alt_idx_i = '0; alt_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check_all_zero("R1");

    // vector table
    for (int i = 0; i < 8; i++) begin
      set_mode(VECS[i].priv, VECS[i].bank);
      wr_en_i    = VECS[i].we;
      wr_idx_i   = VECS[i].widx;
      wr_data_i  = VECS[i].wdata;
      rd_a_idx_i = VECS[i].ra;
      rd_b_idx_i = VECS[i].rb;
      #1;
      chk(vec_req(i), rd_a_data_o, VECS[i].ea);
      chk(vec_req(i), rd_b_data_o, VECS[i].eb);
      tick();
    end
    wr_en_i = 1'b0;

    // R6 transfer write from user mode lands in high bank
    set_mode(1'b0, 1'b0);
    alt_idx_i = 3'd3; alt_we_i = 1'b1; alt_wdata_i = 32'h33333333;
    rd_a_idx_i = 4'd3;
    #1;
    chk("R6", alt_rdata_o, 32'h0);
    tick();
    alt_we_i = 1'b0;
    #1;
    chk("R6", alt_rdata_o, 32'h33333333);
    chk("R6", rd_a_data_o, 32'h0);
    wr_en_i = 1'b1; wr_idx_i = 4'd3; wr_data_i = 32'h0BADF00D;
    tick();
    wr_en_i = 1'b0;
    #1;
    chk("R6", alt_rdata_o, 32'h33333333);
    chk("R6", rd_a_data_o, 32'h0BADF00D);
    set_mode(1'b1, 1'b1);
    #1;
    chk("R6", rd_a_data_o, 32'h33333333);
    chk("R6", alt_rdata_o, 32'h0BADF00D);

    // R10 same index on both write paths
    @(negedge clk_i);
    set_mode(1'b1, 1'b0);
    wr_en_i = 1'b1; wr_idx_i = 4'd4; wr_data_i = 32'h44444444;
    alt_we_i = 1'b1; alt_idx_i = 3'd4; alt_wdata_i = 32'h55555555;
    tick();
    wr_en_i = 1'b0; alt_we_i = 1'b0;
    rd_a_idx_i = 4'd4;
    #1;
    chk("R10", rd_a_data_o, 32'h44444444);
    chk("R10", alt_rdata_o, 32'h55555555);
    set_mode(1'b1, 1'b1);
    #1;
    chk("R10", rd_a_data_o, 32'h55555555);
    chk("R10", alt_rdata_o, 32'h44444444);

    // R7 base output follows visible bank
    @(negedge clk_i);
    set_mode(1'b0, 1'b1);
    wr_en_i = 1'b1; wr_idx_i = 4'd0; wr_data_i = 32'hC0C0C0C0;
    tick();
    wr_en_i = 1'b0;
    #1;
    chk("R7", idx_base_o, 32'hC0C0C0C0);
    set_mode(1'b1, 1'b1);
    #1;
    chk("R7", idx_base_o, 32'h0);
    alt_we_i = 1'b1; alt_idx_i = 3'd0; alt_wdata_i = 32'hE0E0E0E0;
    tick();
    alt_we_i = 1'b0;
    #1;
    chk("R7", idx_base_o, 32'h0);
    set_mode(1'b0, 1'b0);
    #1;
    chk("R7", idx_base_o, 32'hE0E0E0E0);

    // R8 old value in write cycle, new value after the edge
    @(negedge clk_i);
    set_mode(1'b1, 1'b1);
    wr_en_i = 1'b1; wr_idx_i = 4'd12; wr_data_i = 32'h12121212;
    rd_a_idx_i = 4'd12; rd_b_idx_i = 4'd12;
    #1;
    chk("R8", rd_a_data_o, 32'h0);
    @(posedge clk_i);
    #1;
    chk("R8", rd_b_data_o, 32'h12121212);
    @(negedge clk_i);
    wr_en_i = 1'b0;

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    check_all_zero("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule